// File: doc/BRIEF.md
# GPIO bank with per-pin interrupt detection

This block is a 32-pin general-purpose I/O bank controlled through a simple register port. The port has a valid strobe, a write flag, a byte address and a 32-bit data word. Each pin works in one of three ways: as a plain input, as a driven output with its own output enable, or as an interrupt source. An interrupt source can be set to respond to a high level, a low level, a rising edge, a falling edge, or to both edges.

Pin inputs are resynchronised before anything looks at them. For each pin the block holds a pending flag and a mask bit, and it raises one combined interrupt line. Software sets the sense of each pin with separate per-pin registers for polarity, edge-or-level and both-edge. It masks pins through one register address and unmasks them through another, and it acknowledges edge events by writing ones to a clear address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is a general input (pin_oe all zero), the output data register is 0, the pending register is 0, the mask register reads all ones (every pin masked), and irq is low.
- R2: pin_out always equals the output data register. Bit i of pin_oe is 1 only when the direction bit (1 = output) is set and the mode bit (1 = interrupt, 0 = general I/O) is clear. A register write takes effect at the clock edge that accepts it.
- R3: A read is accepted on a clock edge with bus_valid high and bus_write low. The read data appears on bus_rdata after that edge and is held until the next read. Reading the input data register returns pin_in delayed by the two-stage synchroniser.
- R4: A pin in interrupt mode with edge select 0 (level) has its pending bit follow the qualified level. With polarity 0 the bit is set while the pin is high, with polarity 1 while it is low. Writing the clear register cannot remove the bit while the level is active.
- R5: A pin in interrupt mode with edge select 1 and both-edge 0 sets its pending bit on a rising edge when polarity is 0, or on a falling edge when polarity is 1. The bit stays set until it is cleared. The pending bit and irq show the event three clock edges after pin_in changes.
- R6: With edge select 1 and both-edge 1, both transitions set the pending bit, whatever the polarity bit holds.
- R7: Writing the pending clear register clears each pending bit written with 1. Bits written with 0 are left unchanged, and the clear register reads as 0.
- R8: A write to the mask register masks every pin written with 0 and leaves pins written with 1 as they were. A write to the mask clear register unmasks every pin written with 1. The mask register reads 1 for a masked pin.
- R9: irq is high exactly when some pin is both pending and unmasked.
- R10: A pin in general I/O mode has its pending bit cleared at the next edge and held at 0.
- R11: Byte addresses: 0x00 mode, 0x04 direction, 0x08 output data, 0x0C input data (read only), 0x10 pending (read only), 0x14 pending clear, 0x18 mask, 0x1C mask clear, 0x20 polarity, 0x24 edge select, 0x4C both-edge. Every other address, and the two clear addresses, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A register write is visible at the ports one edge after it is accepted. A read is due one edge after it is accepted. A pin change reaches the input data register after two edges and reaches pending and irq after three. The bench drives inputs and samples outputs only on falling clock edges, so every wait is counted in whole rising edges from a known starting point. Before it looks at pending or irq it waits the full three edges, and the latency check samples once at two edges, where the event must still be absent, and once at three.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NPIN   = 32;
    localparam int ADDR_W = 7;

    typedef logic [NPIN-1:0] pinvec_t;

    localparam logic [ADDR_W-1:0] OFS_MODE = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_DOUT = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_DIN  = 7'h0C;
    localparam logic [ADDR_W-1:0] OFS_PEND = 7'h10;
    localparam logic [ADDR_W-1:0] OFS_PCLR = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK = 7'h18;
    localparam logic [ADDR_W-1:0] OFS_MCLR = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_POL  = 7'h20;
    localparam logic [ADDR_W-1:0] OFS_EDGE = 7'h24;
    localparam logic [ADDR_W-1:0] OFS_BOTH = 7'h4C;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_MODE, SEL_DIR, SEL_DOUT, SEL_DIN, SEL_PEND,
        SEL_PCLR, SEL_MASK, SEL_MCLR, SEL_POL, SEL_EDGE, SEL_BOTH
    } reg_sel_e;

    typedef struct packed {
        pinvec_t irq_mode;
        pinvec_t dir;
        pinvec_t dout;
        pinvec_t pol;
        pinvec_t edge_sel;
        pinvec_t both;
        pinvec_t mask;
    } cfg_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_MODE: s = SEL_MODE;
            OFS_DIR:  s = SEL_DIR;
            OFS_DOUT: s = SEL_DOUT;
            OFS_DIN:  s = SEL_DIN;
            OFS_PEND: s = SEL_PEND;
            OFS_PCLR: s = SEL_PCLR;
            OFS_MASK: s = SEL_MASK;
            OFS_MCLR: s = SEL_MCLR;
            OFS_POL:  s = SEL_POL;
            OFS_EDGE: s = SEL_EDGE;
            OFS_BOTH: s = SEL_BOTH;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    // event on one pin given current and previous synchronised level
    function automatic logic edge_event(logic cur, logic prev, logic neg, logic any);
        logic rise, fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (any) return rise | fall;
        return neg ? fall : rise;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_sel_e sel,
    input  pinvec_t  wdata,
    output cfg_t     cfg,
    output pinvec_t  pend_clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.irq_mode <= '0;
            cfg.dir      <= '0;
            cfg.dout     <= '0;
            cfg.pol      <= '0;
            cfg.edge_sel <= '0;
            cfg.both     <= '0;
            cfg.mask     <= '1;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: cfg.irq_mode <= wdata;
                SEL_DIR:  cfg.dir      <= wdata;
                SEL_DOUT: cfg.dout     <= wdata;
                SEL_POL:  cfg.pol      <= wdata;
                SEL_EDGE: cfg.edge_sel <= wdata;
                SEL_BOTH: cfg.both     <= wdata;
                SEL_MASK: cfg.mask     <= cfg.mask | ~wdata;
                SEL_MCLR: cfg.mask     <= cfg.mask & ~wdata;
                default:  ;
            endcase
        end
    end

    assign pend_clr = (wr_en && sel == SEL_PCLR) ? wdata : '0;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t lvl,
    input  pinvec_t irq_mode,
    input  pinvec_t pol,
    input  pinvec_t edge_sel,
    input  pinvec_t both,
    input  pinvec_t pend_clr,
    output pinvec_t pending
);
    pinvec_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            logic hit;
            assign hit = edge_event(lvl[i], prev[i], pol[i], both[i]);
            always_ff @(posedge clk) begin
                if (rst)               pending[i] <= 1'b0;
                else if (!irq_mode[i]) pending[i] <= 1'b0;
                else if (!edge_sel[i]) pending[i] <= lvl[i] ^ pol[i];
                else if (hit)          pending[i] <= 1'b1;
                else if (pend_clr[i])  pending[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    reg_sel_e sel;
    cfg_t     cfg;
    pinvec_t  pend_clr;
    pinvec_t  lvl;
    pinvec_t  pending;
    pinvec_t  rd_mux;

    assign sel = decode_addr(bus_addr);

    gpio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_valid & bus_write),
        .sel      (sel),
        .wdata    (bus_wdata),
        .cfg      (cfg),
        .pend_clr (pend_clr)
    );

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl)
    );

    gpio_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .irq_mode (cfg.irq_mode),
        .pol      (cfg.pol),
        .edge_sel (cfg.edge_sel),
        .both     (cfg.both),
        .pend_clr (pend_clr),
        .pending  (pending)
    );

    always_comb begin
        case (sel)
            SEL_MODE: rd_mux = cfg.irq_mode;
            SEL_DIR:  rd_mux = cfg.dir;
            SEL_DOUT: rd_mux = cfg.dout;
            SEL_DIN:  rd_mux = lvl;
            SEL_PEND: rd_mux = pending;
            SEL_MASK: rd_mux = cfg.mask;
            SEL_POL:  rd_mux = cfg.pol;
            SEL_EDGE: rd_mux = cfg.edge_sel;
            SEL_BOTH: rd_mux = cfg.both;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
    end

    assign pin_out = cfg.dout;
    assign pin_oe  = cfg.dir & ~cfg.irq_mode;
    assign irq     = |(pending & ~cfg.mask);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input pinvec_t           bus_wdata,
    input pinvec_t           irq_mode,
    input pinvec_t           edge_sel,
    input pinvec_t           pol,
    input pinvec_t           mask,
    input pinvec_t           pending,
    input pinvec_t           lvl
);
    logic wr_mask, wr_mclr, wr_pclr;
    assign wr_mask = bus_valid && bus_write && bus_addr == OFS_MASK;
    assign wr_mclr = bus_valid && bus_write && bus_addr == OFS_MCLR;
    assign wr_pclr = bus_valid && bus_write && bus_addr == OFS_PCLR;

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> ((mask | $past(bus_wdata)) == '1));

    // R8
    mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_mclr |=> ((mask & $past(bus_wdata)) == '0));

    // R7
    pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pclr |=> (($past(pending & irq_mode & edge_sel & ~bus_wdata) & ~pending) == '0));

    // R4
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (pending & $past(irq_mode & ~edge_sel)) == ($past(lvl ^ pol) & $past(irq_mode & ~edge_sel)));

    // R10
    gen_mode_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (pending & ~irq_mode & ~$past(irq_mode)) == '0);
endmodule

bind gpio_irq_bank gpio_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_mode  (cfg.irq_mode),
    .edge_sel  (cfg.edge_sel),
    .pol       (cfg.pol),
    .mask      (cfg.mask),
    .pending   (pending),
    .lvl       (lvl)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        rst = 1'b1;
        wait_edges(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", pin_oe, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(7'h08, d); chk("R1 dout", d, 32'h0);
        rd(7'h10, d); chk("R1 pending", d, 32'h0);
        rd(7'h18, d); chk("R1 mask", d, 32'hFFFF_FFFF);
        rd(7'h00, d); chk("R1 mode", d, 32'h0);

        // R2 output drive
        wr(7'h08, 32'h1234_5678);
        wr(7'h04, 32'h0000_FFFF);
        chk("R2 pin_out", pin_out, 32'h1234_5678);
        chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
        wr(7'h00, 32'h0000_0001);
        chk("R2 oe in irq mode", pin_oe, 32'h0000_FFFE);
        wr(7'h00, 32'h0);
        wr(7'h04, 32'h0);

        // R3 input data through synchroniser
        pin_in = 32'hA5C3_0F96;
        wait_edges(3);
        rd(7'h0C, d); chk("R3 din", d, 32'hA5C3_0F96);
        pin_in = '0;
        wait_edges(3);

        // R11 unmapped and clear addresses read zero; config readback
        rd(7'h2C, d); chk("R11 unmapped", d, 32'h0);
        rd(7'h14, d); chk("R11 pclr read", d, 32'h0);
        wr(7'h4C, 32'h0F0F_0000);
        rd(7'h4C, d); chk("R11 both readback", d, 32'h0F0F_0000);
        wr(7'h4C, 32'h0);

        // Sweep: pins x sense modes
        for (int pi = 0; pi < 3; pi++) begin
            for (int m = 0; m < 5; m++) begin
                int p;
                logic [31:0] b;
                logic e0, e1, e2, e3;
                p  = (pi == 0) ? 0 : (pi == 1) ? 7 : 31;
                b  = 32'h1 << p;
                e0 = (m == 1);
                e1 = (m == 0) || (m == 2) || (m == 4);
                e2 = (m == 0);
                e3 = (m == 1) || (m == 3) || (m == 4);
                wr(7'h20, (m == 1 || m == 3 || m == 4) ? b : 32'h0);
                wr(7'h24, (m >= 2) ? b : 32'h0);
                wr(7'h4C, (m == 4) ? b : 32'h0);
                wr(7'h1C, b);
                wr(7'h00, b);
                wait_edges(4);
                wr(7'h14, b);
                // R4 level low stays pending after clear; edges start idle
                rd(7'h10, d); chk((m < 2) ? "R4 idle" : "R5 idle", d, e0 ? b : 32'h0);
                pin_in = b;
                wait_edges(3);
                rd(7'h10, d);
                chk((m < 2) ? "R4 rise" : (m == 4) ? "R6 rise" : "R5 rise", d, e1 ? b : 32'h0);
                wr(7'h14, b);
                rd(7'h10, d);
                chk((m < 2) ? "R4 clear while active" : "R7 clear", d, e2 ? b : 32'h0);
                pin_in = '0;
                wait_edges(3);
                rd(7'h10, d);
                chk((m < 2) ? "R4 fall" : (m == 4) ? "R6 fall" : "R5 fall", d, e3 ? b : 32'h0);
                chk("R9 irq unmasked", {31'b0, irq}, {31'b0, e3});
                wr(7'h18, ~b);
                chk("R9 irq masked", {31'b0, irq}, 32'h0);
                rd(7'h18, d); chk("R8 mask read", d, 32'hFFFF_FFFF);
                wr(7'h00, 32'h0);
                wait_edges(1);
                rd(7'h10, d); chk("R10 general mode clears", d, 32'h0);
            end
        end

        // R5 latency and R7 zero-write, R8 partial mask
        wr(7'h20, 32'h0);
        wr(7'h24, 32'h0000_0008);
        wr(7'h4C, 32'h0);
        wr(7'h1C, 32'h0000_0008);
        wr(7'h00, 32'h0000_0008);
        wait_edges(2);
        pin_in = 32'h0000_0008;
        wait_edges(2);
        chk("R5 not yet at two edges", {31'b0, irq}, 32'h0);
        wait_edges(1);
        chk("R5 irq at three edges", {31'b0, irq}, 32'h1);
        wr(7'h14, 32'h0);
        rd(7'h10, d); chk("R7 zero write", d, 32'h0000_0008);
        wr(7'h14, 32'hFFFF_FFF7);
        rd(7'h10, d); chk("R7 other bits", d, 32'h0000_0008);
        wr(7'h1C, 32'h0000_00F0);
        rd(7'h18, d); chk("R8 unmask", d, 32'hFFFF_FF07);
        wr(7'h18, 32'hFFFF_FFF7);
        rd(7'h18, d); chk("R8 mask zeros", d, 32'hFFFF_FF0F);
        chk("R9 masked pending", {31'b0, irq}, 32'h0);
        wr(7'h1C, 32'h0000_0008);
        chk("R9 unmask pending", {31'b0, irq}, 32'h1);
        wr(7'h14, 32'h0000_0008);
        rd(7'h10, d); chk("R7 clear one", d, 32'h0);

        finish_run();
    end
endmodule